// File: doc/BRIEF.md
# Feed-Latched Watchdog Timer

This block is a watchdog built from a binary prescaler and an 8-bit down counter. Each counting tick arrives on one clock-enable input and comes from an already-selected counting clock. Software reaches the block over a small register bus with single-cycle writes and combinational reads. A control write does not change the running configuration at once. It lands in a shadow copy, and that copy becomes active only when software completes a two-write feed handshake. The same feed reloads the counter and restarts the prescaler from zero.

When the counter underflows, it reloads and raises an overflow flag. In watchdog mode the block also drives a reset pulse of fixed length. In timer mode it raises an interrupt for as long as the flag stays set. A clock-select bit passes through the same shadow path and comes out on a pin, where an external source-switching stage can read it.

Top module: `wdog_feed_timer`

## Requirements
- R1: After reset the shadow and the active configuration both read 0x1E (run 0, prescale 7, reset mode, select 0). The reload value and the counter are 0xFF, the flag is 0, and wd_rst_o, irq_o and clk_sel_o are low.
- R2: Bus addresses: 0 is the control register, 1 is reload, 2 is the first feed register, 3 is the second feed register, 4 reads the counter and 5 reads the active configuration. In the control layout, bit 0 is run, bits 3:1 are the prescale code, bit 4 is the reset enable, bit 5 is the clock select and bit 6 is the overflow flag. Addresses 0 and 5 read {0, flag, config[5:0]}. Addresses 2, 3, 6 and 7 read 0.
- R3: A control write updates only the shadow copy. The active configuration is unchanged until a feed completes.
- R4: A feed completes only when 0xA5 is written to address 2 and the very next bus write is 0x5A to address 3. A wrong first value, a wrong second value, any other write in between, or a second write with no first write changes nothing and returns the handshake to idle.
- R5: On the edge that completes a feed, the active configuration takes the shadow value, the counter takes the reload value and the prescaler clears.
- R6: While run is 1, the counter moves one step every 2^(code+6) cycles in which cnt_tick is high. Cycles with cnt_tick low do not advance the prescaler.
- R7: A step taken at count 0 reloads the counter from the reload register and sets the flag.
- R8: In timer mode (bit 4 = 0), irq_o is high whenever the flag is set. In reset mode, irq_o stays low.
- R9: In reset mode an underflow drives wd_rst_o high for exactly RST_CYCLES cycles, starting the cycle after the underflow edge.
- R10: Writing the control register with bit 6 = 0 clears the flag, and writing 1 leaves it unchanged. If an underflow happens in the same cycle, the set wins.
- R11: While the active run bit is 0, the prescaler and the counter hold their values.
- R12: clk_sel_o follows the active clock-select bit, so it changes only through a feed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_tick | input | 1 | One counting-clock tick per high cycle |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| wd_rst_o | output | 1 | Reset pulse on underflow in reset mode |
| irq_o | output | 1 | Interrupt level in timer mode |
| clk_sel_o | output | 1 | Active counting-clock selection |

## Verification
The embedded properties check, on every cycle, the properties that are local in time. A control write or an unarmed second feed write leaves the active configuration alone. A feed loads the counter and clears the prescaler. A run bit of 0 or an idle tick freezes counting. An underflow sets the flag and reloads, and any rise of the reset pulse follows a flagged underflow in reset mode.

Other behaviours need whole sequences, and only the bench scenarios can show them. These include broken handshakes spread over several writes, the exact division for each prescale code under irregular ticks, the full pulse length, and the flag-clearing rules. A behavioural model compares every register read and output on every cycle.

// File: rtl/wdog_feed_timer.sv
module wdog_feed_timer #(
  parameter int RST_CYCLES = 16,
  parameter int BASE_LOG   = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cnt_tick,
  input  logic       bus_wr,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       wd_rst_o,
  output logic       irq_o,
  output logic       clk_sel_o
);
  localparam int PW = BASE_LOG + 8;
  localparam int RW = $clog2(RST_CYCLES + 1);
  localparam logic [5:0] CFG_INIT = 6'h1E;
  localparam logic [RW-1:0] RST_LOAD = RW'(RST_CYCLES);

  logic [5:0]    sh_q, act_q;
  logic [7:0]    reload_q, cnt_q;
  logic [PW-1:0] pre_q;
  logic [RW-1:0] rcnt_q;
  logic          ovf_q, armed_q;

  wire [PW-1:0] mask = {PW{1'b1}} >> (3'd7 - act_q[3:1]);
  wire feed  = bus_wr && bus_addr == 3'd3 && bus_wdata == 8'h5A && armed_q;
  wire adv   = act_q[0] && cnt_tick && !feed;
  wire step  = adv && pre_q == mask;
  wire uf    = step && cnt_q == 8'd0;
  wire clr   = bus_wr && bus_addr == 3'd0 && !bus_wdata[6];

  assign wd_rst_o  = rcnt_q != '0;
  assign irq_o     = ovf_q && !act_q[4];
  assign clk_sel_o = act_q[5];

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = {1'b0, ovf_q, sh_q};
      3'd1:    bus_rdata = reload_q;
      3'd4:    bus_rdata = cnt_q;
      3'd5:    bus_rdata = {1'b0, ovf_q, act_q};
      default: bus_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= CFG_INIT;
      reload_q <= 8'hFF;
      armed_q  <= 1'b0;
    end else if (bus_wr) begin
      armed_q <= bus_addr == 3'd2 && bus_wdata == 8'hA5;
      if (bus_addr == 3'd0) sh_q <= bus_wdata[5:0];
      if (bus_addr == 3'd1) reload_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= CFG_INIT;
      cnt_q <= 8'hFF;
      pre_q <= '0;
    end else if (feed) begin
      act_q <= sh_q;
      cnt_q <= reload_q;
      pre_q <= '0;
    end else if (adv) begin
      if (step) begin
        pre_q <= '0;
        cnt_q <= uf ? reload_q : cnt_q - 8'd1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q  <= 1'b0;
      rcnt_q <= '0;
    end else begin
      if (uf) ovf_q <= 1'b1;
      else if (clr) ovf_q <= 1'b0;
      if (uf && act_q[4]) rcnt_q <= RST_LOAD;
      else if (rcnt_q != '0) rcnt_q <= rcnt_q - 1'b1;
    end
  end

  p_shadow_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd0) |=> $stable(act_q));
  p_unarmed_feed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd3 && !armed_q) |=> $stable(act_q));
  p_feed_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    feed |=> (cnt_q == $past(reload_q) && pre_q == '0 && act_q == $past(sh_q)));
  p_idle_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_tick && !feed) |=> ($stable(pre_q) && $stable(cnt_q)));
  p_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    uf |=> (ovf_q && cnt_q == $past(reload_q)));
  p_pulse_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_rst_o) |-> (ovf_q && act_q[4]));
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q[0] && !feed) |=> ($stable(pre_q) && $stable(cnt_q)));
endmodule

// File: tb/wdog_feed_timer_tb.sv
module wdog_feed_timer_tb_top;
  localparam int RSTC = 16;
  logic clk = 1'b0, rst_n = 1'b0, cnt_tick = 1'b1, bus_wr = 1'b0;
  logic [2:0] bus_addr = 3'd4;
  logic [7:0] bus_wdata = 8'h00, bus_rdata;
  logic wd_rst_o, irq_o, clk_sel_o;
  int checks = 0, errors = 0, cyc = 0;
  bit rand_tick = 1'b0, done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  logic [5:0] m_sh, m_act;
  logic [7:0] m_reload, m_cnt, exp_rd;
  int m_pre, m_rstc;
  bit m_flag, m_armed, m_fd, m_uf;

  wdog_feed_timer #(.RST_CYCLES(RSTC), .BASE_LOG(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wd_rst_o(wd_rst_o), .irq_o(irq_o), .clk_sel_o(clk_sel_o));

  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    cnt_tick = rand_tick ? lfsr[0] : 1'b1;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sh = 6'h1E; m_act = 6'h1E; m_reload = 8'hFF; m_cnt = 8'hFF;
      m_pre = 0; m_rstc = 0; m_flag = 0; m_armed = 0;
    end else begin
      m_fd = bus_wr && bus_addr == 3'd3 && bus_wdata == 8'h5A && m_armed;
      m_uf = 0;
      if (m_fd) begin
        m_act = m_sh; m_cnt = m_reload; m_pre = 0;
      end else if (m_act[0] && cnt_tick) begin
        if (m_pre == (1 << (int'(m_act[3:1]) + 6)) - 1) begin
          m_pre = 0;
          if (m_cnt == 0) begin m_cnt = m_reload; m_uf = 1; end
          else m_cnt = m_cnt - 1;
        end else m_pre++;
      end
      if (m_uf && m_act[4]) m_rstc = RSTC;
      else if (m_rstc > 0) m_rstc--;
      if (m_uf) m_flag = 1;
      else if (bus_wr && bus_addr == 3'd0 && !bus_wdata[6]) m_flag = 0;
      if (bus_wr) begin
        if (bus_addr == 3'd0) m_sh = bus_wdata[5:0];
        if (bus_addr == 3'd1) m_reload = bus_wdata;
        m_armed = bus_addr == 3'd2 && bus_wdata == 8'hA5;
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      case (bus_addr)
        3'd0: exp_rd = {1'b0, m_flag, m_sh};
        3'd1: exp_rd = m_reload;
        3'd4: exp_rd = m_cnt;
        3'd5: exp_rd = {1'b0, m_flag, m_act};
        default: exp_rd = 8'h00;
      endcase
      chk("R2/R5/R6/R7 read vs model", bus_rdata, exp_rd);
      chk("R9 reset pulse vs model", wd_rst_o, m_rstc != 0);
      chk("R8 irq vs model", irq_o, m_flag && !m_act[4]);
      chk("R12 clock select vs model", clk_sel_o, m_act[5]);
    end
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL timeout: actual=%0d cycles expected<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic bw(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2;
    bus_wr = 1'b0; bus_addr = 3'd4;
  endtask

  task automatic rd(input logic [2:0] a, input string tag, input int exp);
    @(posedge clk); #2;
    bus_addr = a;
    @(negedge clk);
    chk(tag, bus_rdata, exp);
  endtask

  task automatic feed();
    bw(3'd2, 8'hA5);
    bw(3'd3, 8'h5A);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int hi;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rst pulse low", wd_rst_o, 0);
    chk("R1 irq low", irq_o, 0);
    chk("R1 clk select low", clk_sel_o, 0);
    rd(3'd0, "R1 shadow", 8'h1E);
    rd(3'd5, "R1 active", 8'h1E);
    rd(3'd1, "R1 reload", 8'hFF);
    rd(3'd4, "R1 counter", 8'hFF);

    bw(3'd1, 8'h02);
    bw(3'd0, 8'h01);
    rd(3'd0, "R3 shadow written", 8'h01);
    rd(3'd5, "R3 active unchanged", 8'h1E);

    bw(3'd2, 8'hA5); bw(3'd1, 8'h02); bw(3'd3, 8'h5A);
    rd(3'd5, "R4 intervening write", 8'h1E);
    bw(3'd2, 8'hA4); bw(3'd3, 8'h5A);
    rd(3'd5, "R4 wrong first value", 8'h1E);
    bw(3'd3, 8'h5A);
    rd(3'd5, "R4 second without first", 8'h1E);
    bw(3'd2, 8'hA5); bw(3'd3, 8'h5B); bw(3'd3, 8'h5A);
    rd(3'd5, "R4 wrong second value", 8'h1E);
    rd(3'd3, "R2 feed register reads 0", 8'h00);

    feed();
    rd(3'd5, "R5 active loaded", 8'h01);
    rd(3'd4, "R5 counter reloaded", 8'h02);

    hi = 0;
    for (int i = 0; i < 400 && !irq_o; i++) begin @(negedge clk); hi++; end
    chk("R8 timer mode interrupt", irq_o, 1);
    chk("R7 no reset pulse in timer mode", wd_rst_o, 0);
    rd(3'd0, "R7 flag set", 8'h41);
    bw(3'd0, 8'h41);
    rd(3'd0, "R10 writing 1 keeps flag", 8'h41);
    bw(3'd0, 8'h01);
    rd(3'd0, "R10 writing 0 clears flag", 8'h01);
    chk("R10 irq dropped", irq_o, 0);

    rand_tick = 1'b1;
    bw(3'd0, 8'h03);
    feed();
    idle(900);
    bw(3'd0, 8'h05);
    feed();
    idle(1200);
    rand_tick = 1'b0;

    bw(3'd0, 8'h02);
    feed();
    idle(300);
    rd(3'd4, "R11 counter held", 8'h02);

    bw(3'd1, 8'h01);
    bw(3'd0, 8'h11);
    feed();
    for (int i = 0; i < 400 && !wd_rst_o; i++) @(negedge clk);
    chk("R9 reset pulse seen", wd_rst_o, 1);
    chk("R8 irq low in reset mode", irq_o, 0);
    hi = 0;
    while (wd_rst_o && hi < 100) begin hi++; @(negedge clk); end
    chk("R9 pulse length", hi, RSTC);

    bw(3'd0, 8'h21);
    chk("R12 select waits for feed", clk_sel_o, 0);
    feed();
    @(negedge clk);
    chk("R12 select after feed", clk_sel_o, 1);
    idle(200);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule